// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block is the host-side data port of a network controller. The host loads a start address and a byte count. It then reads or writes the controller's byte-addressed memory through one data port, one access at a time. Each access moves 1, 2 or 4 bytes. A one-bit width setting picks byte or halfword for ordinary accesses, and a separate doubleword strobe always moves four bytes. Multi-byte values are little-endian.

After every access the address advances by the bytes moved. When the new address lands exactly on the ring stop address, it is reloaded from the ring start address. The count drops by the bytes moved; when it would reach or pass zero, it is pinned at zero and a one-cycle completion pulse is raised. Two windows of memory are reachable. The first is a 32-byte address area at the bottom, filled at reset from the station address. The second is a packet RAM window set by parameters. Anything else reads as all ones and ignores writes.

The loads of address and count are plain input strobes. A load takes priority over an access in the same cycle, and that access is dropped.

Top module: `rdma_port`

## Requirements
- R1: An access moves 1 byte when `cfg_wide`=0 and 2 bytes when `cfg_wide`=1. With `acc_dword`=1 it moves 4 bytes whatever `cfg_wide` is. `cur_addr` advances by the bytes moved.
- R2: If the advanced address equals `ring_stop`, `cur_addr` becomes `ring_start`. An address that steps past `ring_stop` without equalling it is not wrapped.
- R3: If `count` is at most the bytes moved, `count` becomes 0 and `dma_done` is high for one cycle. Otherwise `count` drops by the bytes moved.
- R4: A write while `count` is 0 changes no memory, no address and no count. A read while `count` is 0 still returns data, still advances the address and still pulses `dma_done`.
- R5: Halfword and doubleword accesses use the address with bit 0 cleared. The address advance starts from the unmasked address.
- R6: An access is mapped if its aligned address is below 32, or if all of its bytes lie in [PMEM_BASE, PMEM_BASE+PMEM_BYTES). An unmapped read returns all ones in the low 8, 16 or 32 bits and zeros above. An unmapped write is discarded. In a mapped access, a byte that falls in neither window reads as 0xFF and is not written.
- R7: Byte lane k of `wdata`/`rdata` (bits 8k+7:8k) maps to address base+k.
- R8: After reset, address-area byte 2j and byte 2j+1 both hold station byte j. Station byte j is `mac_addr[47-8j -: 8]` for j<6, 0x00 for j=6..13, and 0x57 for j=14,15. The area stays writable.
- R9: `rdata`, `cur_addr`, `count` and `dma_done` all change at the first clock edge after the strobe and not before. Reset clears `cur_addr`, `count`, `rdata` and `dma_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mac_addr | input | 48 | Station address, first byte in bits 47:40 |
| cfg_wide | input | 1 | 1: halfword accesses, 0: byte accesses |
| ring_start | input | AW | Ring start address (wrap target) |
| ring_stop | input | AW | Ring stop address (wrap trigger) |
| addr_ld | input | 1 | Load `addr_val` into the remote address |
| addr_val | input | AW | Remote start address to load |
| count_ld | input | 1 | Load `count_val` into the remote count |
| count_val | input | AW | Remote byte count to load |
| acc_rd | input | 1 | Read strobe on the data port |
| acc_wr | input | 1 | Write strobe on the data port |
| acc_dword | input | 1 | Access is a 4-byte access |
| wdata | input | 32 | Write data, little-endian |
| rdata | output | 32 | Registered read data |
| cur_addr | output | AW | Current remote address |
| count | output | AW | Remaining remote byte count |
| dma_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with PMEM_BASE=16384 and PMEM_BYTES=256, so the packet window ends at 0x4100. At that size a few accesses reach the upper edge of the window, where a doubleword straddling the end must read as all ones. The ring is set inside the window so that exact-hit wrapping and overshooting past the stop address can both be reached. Accesses near address 30 exercise a mapped doubleword whose upper bytes fall in the gap between the two windows.

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter int AW         = 16,
  parameter int PMEM_BASE  = 16384,
  parameter int PMEM_BYTES = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [47:0]   mac_addr,
  input  logic          cfg_wide,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_stop,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_val,
  input  logic          count_ld,
  input  logic [AW-1:0] count_val,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic          acc_dword,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] count,
  output logic          dma_done
);
  localparam int PMW = (PMEM_BYTES > 1) ? $clog2(PMEM_BYTES) : 1;
  localparam logic [AW:0] PM_LO = (AW+1)'(PMEM_BASE);
  localparam logic [AW:0] PM_HI = (AW+1)'(PMEM_BASE + PMEM_BYTES);
  localparam logic [AW:0] AREA_TOP = (AW+1)'(32);

  logic [7:0] prom [32];
  logic [7:0] pmem [PMEM_BYTES];

  logic [2:0]    nbytes;
  logic [AW-1:0] base_a;
  logic [AW:0]   ext_a, last_a;
  logic          in_win, loading, go_rd, go_wr, go;
  logic [AW:0]   la [4];
  logic [3:0]    lane_area, lane_pm;
  logic [7:0]    rb [4];
  logic [31:0]   mask, rd_word;
  logic [AW-1:0] step_a;

  assign nbytes  = acc_dword ? 3'd4 : (cfg_wide ? 3'd2 : 3'd1);
  assign base_a  = (nbytes != 3'd1) ? {cur_addr[AW-1:1], 1'b0} : cur_addr;
  assign ext_a   = {1'b0, base_a};
  assign last_a  = ext_a + (AW+1)'(nbytes) - (AW+1)'(1);
  assign in_win  = (ext_a < AREA_TOP) || (ext_a >= PM_LO && last_a < PM_HI);
  assign loading = addr_ld | count_ld;
  assign go_rd   = acc_rd & ~loading;
  assign go_wr   = acc_wr & ~acc_rd & ~loading & (count != '0);
  assign go      = go_rd | go_wr;
  assign mask    = (nbytes == 3'd4) ? 32'hFFFF_FFFF : (nbytes == 3'd2) ? 32'h0000_FFFF : 32'h0000_00FF;
  assign step_a  = cur_addr + AW'(nbytes);

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      la[i]        = ext_a + (AW+1)'(i);
      lane_area[i] = la[i] < AREA_TOP;
      lane_pm[i]   = la[i] >= PM_LO && la[i] < PM_HI;
      rb[i]        = lane_area[i] ? prom[la[i][4:0]] :
                     lane_pm[i]   ? pmem[PMW'(la[i] - PM_LO)] : 8'hFF;
    end
  end

  assign rd_word = in_win ? ({rb[3], rb[2], rb[1], rb[0]} & mask) : mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 32; k++) begin
        if (k / 2 < 6)        prom[k] <= mac_addr[47 - 8*(k/2) -: 8];
        else if (k / 2 >= 14) prom[k] <= 8'h57;
        else                  prom[k] <= 8'h00;
      end
    end else if (go_wr && in_win) begin
      for (int i = 0; i < 4; i++)
        if (i < int'(nbytes) && lane_area[i]) prom[la[i][4:0]] <= wdata[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (go_wr && in_win) begin
      for (int i = 0; i < 4; i++)
        if (i < int'(nbytes) && lane_pm[i]) pmem[PMW'(la[i] - PM_LO)] <= wdata[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      count    <= '0;
      rdata    <= '0;
      dma_done <= 1'b0;
    end else begin
      dma_done <= 1'b0;
      if (addr_ld)  cur_addr <= addr_val;
      if (count_ld) count    <= count_val;
      if (go) begin
        cur_addr <= (step_a == ring_stop) ? ring_start : step_a;
        if (count <= AW'(nbytes)) begin
          count    <= '0;
          dma_done <= 1'b1;
        end else begin
          count <= count - AW'(nbytes);
        end
      end
      if (go_rd) rdata <= rd_word;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd && acc_wr)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (cur_addr == $past(cur_addr + AW'(nbytes))) || (cur_addr == $past(ring_start))); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && count > AW'(nbytes)) |=> (count == $past(count - AW'(nbytes))) && !dma_done); // R3

  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> count == '0); // R3

  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !acc_rd && !loading && count == '0) |=> $stable(cur_addr) && $stable(count) && !dma_done); // R4

  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (go_rd && !in_win) |=> rdata == $past(mask)); // R6
endmodule

// File: tb/rdma_port_test.sv
module rdma_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [47:0]   mac_addr = 48'h02_11_22_33_44_55;
  logic          cfg_wide = 1'b0;
  logic [AW-1:0] ring_start = 16'h4000;
  logic [AW-1:0] ring_stop  = 16'h4080;
  logic          addr_ld = 1'b0, count_ld = 1'b0;
  logic [AW-1:0] addr_val = '0, count_val = '0;
  logic          acc_rd = 1'b0, acc_wr = 1'b0, acc_dword = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [AW-1:0] cur_addr, count;
  logic          dma_done;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdma_port #(.AW(AW), .PMEM_BASE(16384), .PMEM_BYTES(256)) uut (
    .clk(clk), .rst_n(rst_n), .mac_addr(mac_addr), .cfg_wide(cfg_wide),
    .ring_start(ring_start), .ring_stop(ring_stop),
    .addr_ld(addr_ld), .addr_val(addr_val), .count_ld(count_ld), .count_val(count_val),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_dword(acc_dword), .wdata(wdata),
    .rdata(rdata), .cur_addr(cur_addr), .count(count), .dma_done(dma_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [AW-1:0] c);
    @(negedge clk);
    addr_ld = 1'b1; addr_val = a; count_ld = 1'b1; count_val = c;
    @(negedge clk);
    addr_ld = 1'b0; count_ld = 1'b0;
  endtask

  task automatic access(input logic rd, input logic dw, input logic [31:0] d);
    @(negedge clk);
    acc_rd = rd; acc_wr = !rd; acc_dword = dw; wdata = d;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0; acc_dword = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset addr", 32'(cur_addr), 32'h0);
    chk("R9 reset count", 32'(count), 32'h0);
    chk("R9 reset rdata", rdata, 32'h0);
    chk("R9 reset done", 32'(dma_done), 32'h0);
  endtask

  task automatic t_prom();
    logic [7:0] sb;
    cfg_wide = 1'b0;
    load(16'h0000, 16'd32);
    for (int k = 0; k < 32; k++) begin
      if (k / 2 < 6)        sb = mac_addr[47 - 8*(k/2) -: 8];
      else if (k / 2 >= 14) sb = 8'h57;
      else                  sb = 8'h00;
      access(1'b1, 1'b0, 32'h0);
      chk("R8 address area byte", rdata, 32'(sb));
    end
    chk("R1 byte advance over area", 32'(cur_addr), 32'h20);
    chk("R3 count spent", 32'(count), 32'h0);
  endtask

  task automatic t_endian();
    cfg_wide = 1'b0;
    load(16'h4000, 16'd8);
    access(1'b0, 1'b1, 32'hA1B2C3D4);
    chk("R1 dword advance", 32'(cur_addr), 32'h4004);
    chk("R3 dword count", 32'(count), 32'd4);
    load(16'h4000, 16'd8);
    access(1'b1, 1'b0, 32'h0);
    chk("R7 lane0 byte", rdata, 32'hD4);
    access(1'b1, 1'b0, 32'h0);
    chk("R7 lane1 byte", rdata, 32'hC3);
    cfg_wide = 1'b1;
    access(1'b1, 1'b0, 32'h0);
    chk("R7 halfword", rdata, 32'hA1B2);
    chk("R1 halfword advance", 32'(cur_addr), 32'h4004);
    load(16'h4000, 16'd8);
    access(1'b1, 1'b1, 32'h0);
    chk("R7 dword read", rdata, 32'hA1B2C3D4);
    cfg_wide = 1'b0;
  endtask

  task automatic t_align();
    cfg_wide = 1'b1;
    load(16'h4001, 16'd8);
    access(1'b1, 1'b0, 32'h0);
    chk("R5 odd halfword data", rdata, 32'hC3D4);
    chk("R5 odd halfword advance", 32'(cur_addr), 32'h4003);
    cfg_wide = 1'b0;
  endtask

  task automatic t_zero_count();
    cfg_wide = 1'b0;
    load(16'h4010, 16'd1);
    access(1'b0, 1'b0, 32'h33);
    chk("R3 last byte count", 32'(count), 32'h0);
    chk("R3 done pulse", 32'(dma_done), 32'h1);
    chk("R1 addr", 32'(cur_addr), 32'h4011);
    load(16'h4010, 16'd0);
    access(1'b0, 1'b0, 32'h5A);
    chk("R4 ignored write addr", 32'(cur_addr), 32'h4010);
    chk("R4 ignored write count", 32'(count), 32'h0);
    chk("R4 ignored write no done", 32'(dma_done), 32'h0);
    access(1'b1, 1'b0, 32'h0);
    chk("R4 read at zero data", rdata, 32'h33);
    chk("R4 read at zero addr", 32'(cur_addr), 32'h4011);
    chk("R4 read at zero done", 32'(dma_done), 32'h1);
  endtask

  task automatic t_count();
    cfg_wide = 1'b1;
    load(16'h4000, 16'd3);
    access(1'b1, 1'b0, 32'h0);
    chk("R3 count 3-2", 32'(count), 32'd1);
    chk("R3 no done yet", 32'(dma_done), 32'h0);
    access(1'b1, 1'b0, 32'h0);
    chk("R3 count floor", 32'(count), 32'd0);
    chk("R3 done on overrun", 32'(dma_done), 32'h1);
    @(negedge clk);
    chk("R3 done single cycle", 32'(dma_done), 32'h0);
    cfg_wide = 1'b0;
  endtask

  task automatic t_wrap();
    ring_start = 16'h4020; ring_stop = 16'h4040;
    cfg_wide = 1'b1;
    load(16'h403E, 16'd10);
    access(1'b0, 1'b0, 32'h1234);
    chk("R2 exact wrap", 32'(cur_addr), 32'h4020);
    chk("R3 count after wrap", 32'(count), 32'd8);
    load(16'h403F, 16'd10);
    access(1'b1, 1'b0, 32'h0);
    chk("R5 aligned read near stop", rdata, 32'h1234);
    chk("R2 overshoot not wrapped", 32'(cur_addr), 32'h4041);
    cfg_wide = 1'b0;
    load(16'h403F, 16'd4);
    access(1'b1, 1'b0, 32'h0);
    chk("R7 high byte", rdata, 32'h12);
    chk("R2 byte wrap", 32'(cur_addr), 32'h4020);
    ring_start = 16'h4000; ring_stop = 16'h4080;
  endtask

  task automatic t_window();
    cfg_wide = 1'b0;
    load(16'h0100, 16'd16);
    access(1'b1, 1'b0, 32'h0);
    chk("R6 unmapped byte", rdata, 32'h0000_00FF);
    cfg_wide = 1'b1;
    access(1'b1, 1'b0, 32'h0);
    chk("R6 unmapped halfword", rdata, 32'h0000_FFFF);
    access(1'b1, 1'b1, 32'h0);
    chk("R6 unmapped dword", rdata, 32'hFFFF_FFFF);
    chk("R6 unmapped still advances", 32'(cur_addr), 32'h0107);
    load(16'h40FE, 16'd8);
    access(1'b0, 1'b0, 32'hBEEF);
    load(16'h40FE, 16'd8);
    access(1'b0, 1'b1, 32'h1111_2222);
    chk("R3 discarded write counts", 32'(count), 32'd4);
    load(16'h40FE, 16'd8);
    access(1'b1, 1'b0, 32'h0);
    chk("R6 write past window discarded", rdata, 32'hBEEF);
    load(16'h40FE, 16'd8);
    access(1'b1, 1'b1, 32'h0);
    chk("R6 dword past window end", rdata, 32'hFFFF_FFFF);
    cfg_wide = 1'b0;
    load(16'h0003, 16'd2);
    access(1'b0, 1'b0, 32'h77);
    cfg_wide = 1'b1;
    load(16'h0002, 16'd2);
    access(1'b1, 1'b0, 32'h0);
    chk("R8 address area writable", rdata, 32'h7711);
    load(16'h001E, 16'd8);
    access(1'b1, 1'b1, 32'h0);
    chk("R6 gap bytes read 0xFF", rdata, 32'hFFFF_5757);
    cfg_wide = 1'b0;
  endtask

  task automatic t_timing();
    cfg_wide = 1'b0;
    load(16'h4000, 16'd8);
    @(negedge clk);
    acc_rd = 1'b1;
    #1;
    chk("R9 addr before edge", 32'(cur_addr), 32'h4000);
    chk("R9 count before edge", 32'(count), 32'd8);
    @(negedge clk);
    acc_rd = 1'b0;
    chk("R9 data after edge", rdata, 32'hD4);
    chk("R9 addr after edge", 32'(cur_addr), 32'h4001);
    chk("R9 count after edge", 32'(count), 32'd7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_prom();
    t_endian();
    t_align();
    t_zero_count();
    t_count();
    t_wrap();
    t_window();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule